// File: doc/BRIEF.md
# System-Management Interrupt Status Register

This block collects eight power-management interrupt sources into one byte that the host reads and writes over a simple register bus. Each bit clears under one of three policies. Some bits track a live source level and drop only when that source drops. Some are sticky and clear when the host reads the register. One bit is sticky and clears only when the host writes a 1 to its position.

The alarm status bit also drives a system-management-interrupt output when its enable input is high. The output stays high for as long as the alarm bit is set, so firmware clears the interrupt by writing a 1 to that bit. The infrared receive line is asynchronous, so it is synchronised inside the block before its edges are detected. Every other input is assumed to be synchronous to `clk`. The register decodes at one address, `STAT_ADDR` (default 0x2C).

Top module: `smi_stat_reg`

## Requirements
- R1: When `rst_n` is sampled low, the register becomes 0x00 and `smi_out` is low.
- R2: Bits 0, 1, 4 and 5 show `mouse_irq`, `kbd_irq`, `kbc_pin` and `abus_irq`, each one clock after the source is sampled. Reads and writes do not change them.
- R3: Bit 2 is set three clock edges after any change of `ir_rx`, whether the change is a rise or a fall. A read of the register clears it.
- R4: Bit 3 is set on any clock edge where `delay_start` is high. A read of the register clears it.
- R5: If a set event and a read arrive on the same edge for bit 2 or bit 3, the bit ends up set.
- R6: Bit 6 is set on any edge where `rtc_alarm` is high. A write with data bit 6 equal to 1 clears it. A write with data bit 6 equal to 0 leaves it unchanged, and so does a read.
- R7: `smi_out` equals bit 6 AND `alarm_en`. It stays high until bit 6 is cleared or the enable drops.
- R8: Bit 7 always reads 0. `bus_rdata` is 0x00 unless `bus_rd` is high and `bus_addr` equals `STAT_ADDR`.
- R9: If `rtc_alarm` is high on the same edge as a write of 1 to bit 6, bit 6 stays set.
- R10: A read or write at any address other than `STAT_ADDR` changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe; with a matching address it clears the read-clear bits at the edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data; only bit 6 has an effect |
| bus_rdata | output | 8 | Read data, combinational, 0x00 when the register is not being read |
| mouse_irq | input | 1 | Mouse interrupt level |
| kbd_irq | input | 1 | Keyboard interrupt level |
| ir_rx | input | 1 | Selected infrared receive line, asynchronous |
| delay_start | input | 1 | Pulse marking the start of the soft-power delay count |
| kbc_pin | input | 1 | Keyboard-controller port pin level |
| abus_irq | input | 1 | Access-bus interrupt level |
| rtc_alarm | input | 1 | Real-time-clock second alarm event |
| alarm_en | input | 1 | Enables `smi_out` from bit 6 |
| smi_out | output | 1 | System-management interrupt request |

## Verification
The assertions check on every cycle that:
- each level bit follows its source one cycle late;
- a set event always leaves its sticky bit high;
- a clear with no competing set always takes effect;
- a sticky bit holds when there is neither event nor clear;
- `smi_out` never rises without the enable;
- bit 7 and the idle read bus stay at zero.

Only the directed scenarios can show the rest. These are the three-edge latency of the synchronised infrared edge detector and the fact that both edge polarities count. They also include the set-wins rule seen through the host bus, a write of 0 or an off-address access leaving bit 6 untouched, and the SMI line persisting across reads until the write-1 clear.

// File: rtl/smi_pkg.sv
// Package: shared constants and types for the SMI status register.
// Assumes an 8-bit register; bit positions are fixed by the host's decoding.
package smi_pkg;
    localparam int DATA_W    = 8;
    localparam int B_MOUSE   = 0;
    localparam int B_KBD     = 1;
    localparam int B_IR      = 2;
    localparam int B_DELAY   = 3;
    localparam int B_KBC     = 4;
    localparam int B_ABUS    = 5;
    localparam int B_ALARM   = 6;
    localparam int B_RSVD    = 7;
    localparam int LVL_CNT   = 4;

    // How a sticky bit is cleared by the host.
    typedef enum logic {
        CLR_ON_READ = 1'b0,
        CLR_ON_W1   = 1'b1
    } clr_policy_e;

    // Maps the index of a level-following source to its register bit.
    function automatic int lvl_bit(input int idx);
        case (idx)
            0:       lvl_bit = B_MOUSE;
            1:       lvl_bit = B_KBD;
            2:       lvl_bit = B_KBC;
            default: lvl_bit = B_ABUS;
        endcase
    endfunction
endpackage

// File: rtl/smi_edge_sync.sv
// Module: synchronises an asynchronous line through STAGES flops, then flags
// any change between two consecutive synchronised samples.
// Assumes STAGES >= 2. The flag is a one-cycle pulse per change, STAGES cycles
// after the line moves.
module smi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    logic [STAGES:0] shr_q;

    // Shift the line through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shr_q <= '0;
        else        shr_q <= {shr_q[STAGES-1:0], din};
    end

    // A change between the newest synchronised sample and the one before it.
    assign edge_o = shr_q[STAGES] ^ shr_q[STAGES-1];
endmodule

// File: rtl/smi_status_bit.sv
// Module: one sticky status bit. A set event beats a clear on the same edge.
// POLICY picks the clear source: a read hit, or a write hit carrying a 1.
// Assumes rd_hit_i and wr_hit_i are already address-qualified.
module smi_status_bit #(
    parameter smi_pkg::clr_policy_e POLICY = smi_pkg::CLR_ON_READ
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_hit_i,
    input  logic wr_hit_i,
    input  logic wdata_bit_i,
    output logic q_o
);
    logic clr;

    // Select the clear condition for the configured policy.
    assign clr = (POLICY == smi_pkg::CLR_ON_W1) ? (wr_hit_i & wdata_bit_i) : rd_hit_i;

    // Update the bit; a set takes priority so no event is lost.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr)   q_o <= 1'b0;
    end

    // R5 / R9: a set event always leaves the bit high.
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    // R3 / R4 / R6: an uncontested clear always takes effect.
    p_clear_applies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && ((POLICY == smi_pkg::CLR_ON_W1) ? (wr_hit_i && wdata_bit_i) : rd_hit_i)) |=> !q_o);

    // R6 / R10: with neither event nor clear, the bit holds.
    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !((POLICY == smi_pkg::CLR_ON_W1) ? (wr_hit_i && wdata_bit_i) : rd_hit_i)) |=> $stable(q_o));
endmodule

// File: rtl/smi_stat_reg.sv
// Module: SMI status register. It holds level-following bits, read-clear sticky
// bits and one write-1-clear alarm bit, and drives the SMI line from the alarm.
// Assumes every input except ir_rx is synchronous to clk. bus_rdata is
// combinational and valid while bus_rd is high.
module smi_stat_reg #(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h2C,
    parameter int              IR_SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              mouse_irq,
    input  logic              kbd_irq,
    input  logic              ir_rx,
    input  logic              delay_start,
    input  logic              kbc_pin,
    input  logic              abus_irq,
    input  logic              rtc_alarm,
    input  logic              alarm_en,
    output logic              smi_out
);
    import smi_pkg::*;

    logic                    sel, rd_hit, wr_hit, ir_edge;
    logic [LVL_CNT-1:0]      lvl_src, lvl_q;
    logic                    ir_q, delay_q, alarm_q;
    logic [DATA_W-1:0]       status;
    logic                    unused_wdata;

    // Address decode for the single register.
    assign sel    = (bus_addr == STAT_ADDR);
    assign rd_hit = bus_rd & sel;
    assign wr_hit = bus_wr & sel;
    assign unused_wdata = ^{bus_wdata[7], bus_wdata[5:0]};

    // Gather the level sources in index order.
    assign lvl_src = {abus_irq, kbc_pin, kbd_irq, mouse_irq};

    // Register the level sources so the register resets to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_src;
    end

    // Infrared edge detector behind a synchroniser.
    smi_edge_sync #(.STAGES(IR_SYNC)) u_ir_sync (
        .clk(clk), .rst_n(rst_n), .din(ir_rx), .edge_o(ir_edge)
    );

    // Infrared activity bit, cleared on read.
    smi_status_bit #(.POLICY(CLR_ON_READ)) u_ir_bit (
        .clk(clk), .rst_n(rst_n), .set_i(ir_edge), .rd_hit_i(rd_hit),
        .wr_hit_i(wr_hit), .wdata_bit_i(bus_wdata[B_IR]), .q_o(ir_q)
    );

    // Delay-start bit, cleared on read.
    smi_status_bit #(.POLICY(CLR_ON_READ)) u_delay_bit (
        .clk(clk), .rst_n(rst_n), .set_i(delay_start), .rd_hit_i(rd_hit),
        .wr_hit_i(wr_hit), .wdata_bit_i(bus_wdata[B_DELAY]), .q_o(delay_q)
    );

    // Alarm bit, cleared by writing a 1.
    smi_status_bit #(.POLICY(CLR_ON_W1)) u_alarm_bit (
        .clk(clk), .rst_n(rst_n), .set_i(rtc_alarm), .rd_hit_i(rd_hit),
        .wr_hit_i(wr_hit), .wdata_bit_i(bus_wdata[B_ALARM]), .q_o(alarm_q)
    );

    // Assemble the status word; level bits placed through the index map.
    always_comb begin
        status          = '0;
        for (int i = 0; i < LVL_CNT; i++) status[lvl_bit(i)] = lvl_q[i];
        status[B_IR]    = ir_q;
        status[B_DELAY] = delay_q;
        status[B_ALARM] = alarm_q;
        status[B_RSVD]  = 1'b0;
    end

    // Drive read data only during a read hit.
    assign bus_rdata = rd_hit ? status : '0;

    // SMI request from the enabled alarm bit.
    assign smi_out = alarm_q & alarm_en;

    // R2: each level bit shows its source one cycle later.
    p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[B_MOUSE] == $past(mouse_irq)) && (status[B_KBD] == $past(kbd_irq))
              && (status[B_KBC] == $past(kbc_pin)) && (status[B_ABUS] == $past(abus_irq)));

    // R7: no SMI without the enable.
    p_smi_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_en |-> !smi_out);

    // R8: the reserved bit never reads as 1.
    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[B_RSVD]);

    // R8: the read bus is quiet while no read is in progress.
    p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/sim_smi_stat_reg.sv
`timescale 1ns/1ps
module sim_smi_stat_reg;
    localparam logic [7:0] ADDR  = 8'h2C;
    localparam logic [7:0] OTHER = 8'h2D;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic       bus_rd = 0, bus_wr = 0;
    logic       mouse_irq = 0, kbd_irq = 0, ir_rx = 0, delay_start = 0;
    logic       kbc_pin = 0, abus_irq = 0, rtc_alarm = 0, alarm_en = 0, smi_out;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    smi_stat_reg u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mouse_irq(mouse_irq), .kbd_irq(kbd_irq),
        .ir_rx(ir_rx), .delay_start(delay_start), .kbc_pin(kbc_pin), .abus_irq(abus_irq),
        .rtc_alarm(rtc_alarm), .alarm_en(alarm_en), .smi_out(smi_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Read at addr: sample during the strobe; the clear lands at the next edge.
    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(ADDR, d);        check("R1 reset value", d, 8'h00);
        check("R1 smi after reset", {7'd0, smi_out}, 8'h00);
        #1 check("R8 idle bus", bus_rdata, 8'h00);
    endtask

    task automatic t_level();
        logic [7:0] d;
        @(negedge clk); mouse_irq = 1; kbc_pin = 1;
        rd(ADDR, d);        check("R2 mouse+kbc", d, 8'h11);
        wr(ADDR, 8'hFF);
        rd(ADDR, d);        check("R2 level kept after write", d, 8'h11);
        @(negedge clk); mouse_irq = 0; kbc_pin = 0; kbd_irq = 1; abus_irq = 1;
        rd(ADDR, d);        check("R2 kbd+abus", d, 8'h22);
        @(negedge clk); kbd_irq = 0; abus_irq = 0;
        rd(ADDR, d);        check("R2 cleared at source", d, 8'h00);
    endtask

    task automatic t_ir();
        logic [7:0] d;
        @(negedge clk); ir_rx = 1;
        @(negedge clk); @(negedge clk);
        rd(ADDR, d);        check("R3 rise sets bit2", d, 8'h04);
        rd(ADDR, d);        check("R3 read clears bit2", d, 8'h00);
        @(negedge clk); ir_rx = 0;
        @(negedge clk); @(negedge clk);
        rd(ADDR, d);        check("R3 fall sets bit2", d, 8'h04);
        rd(ADDR, d);        check("R3 cleared again", d, 8'h00);
    endtask

    task automatic t_delay();
        logic [7:0] d;
        @(negedge clk); delay_start = 1;
        @(negedge clk); delay_start = 0;
        rd(OTHER, d);       check("R10 off-address read data", d, 8'h00);
        rd(ADDR, d);        check("R4 delay bit set, R10 kept", d, 8'h08);
        rd(ADDR, d);        check("R4 read clears", d, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        @(negedge clk); delay_start = 1;
        @(negedge clk); bus_addr = ADDR; bus_rd = 1;
        #1 d = bus_rdata;   check("R5 bit set before collision", d, 8'h08);
        @(negedge clk); bus_rd = 0; delay_start = 0;
        rd(ADDR, d);        check("R5 set beat read-clear", d, 8'h08);
        rd(ADDR, d);        check("R5 then clears", d, 8'h00);
    endtask

    task automatic t_alarm();
        logic [7:0] d;
        @(negedge clk); rtc_alarm = 1;
        @(negedge clk); rtc_alarm = 0;
        check("R7 masked smi", {7'd0, smi_out}, 8'h00);
        rd(ADDR, d);        check("R6 alarm set", d, 8'h40);
        wr(ADDR, 8'hBF);
        rd(ADDR, d);        check("R6 write 0 no effect, read no clear", d, 8'h40);
        wr(OTHER, 8'h40);
        rd(ADDR, d);        check("R10 off-address write ignored", d, 8'h40);
        @(negedge clk); alarm_en = 1;
        #1 check("R7 smi asserted", {7'd0, smi_out}, 8'h01);
        @(negedge clk); bus_addr = ADDR; bus_wdata = 8'h40; bus_wr = 1; rtc_alarm = 1;
        @(negedge clk); bus_wr = 0; rtc_alarm = 0;
        rd(ADDR, d);        check("R9 set beat write-1", d, 8'h40);
        check("R7 smi persists", {7'd0, smi_out}, 8'h01);
        wr(ADDR, 8'h40);
        rd(ADDR, d);        check("R6 write 1 clears", d, 8'h00);
        check("R7 smi drops", {7'd0, smi_out}, 8'h00);
        alarm_en = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_level();
        t_ir();
        t_delay();
        t_set_wins();
        t_alarm();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule